// File: doc/BRIEF.md
# Serial NOR Page-Program Write Buffer

This block stages one full flash page and then writes it to a serial NOR device in a single chip-select burst. A 32-bit host data port packs four bytes per word, least significant byte first. Thirty-two consecutive word writes fill the 128-byte store. After the start address is loaded, the buffered-write command sends the page-program opcode, the 24-bit address (most significant byte first) and all 128 bytes in ascending order on a mode-0 serial line.

The store is shared with the read-prefetch path. A mode bit hands it to page programming. The host changes the bit and polls until the new value reads back, because a change is held off while a burst is in flight. A second command writes a single byte from a byte register at the current address and then advances that address. The host uses it for tail bytes that do not fill a page, after the store has been handed back to read use. The host issues write-enable and polls device status by other means.

Top module: `nor_pp_writer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the pending-command bits are 0, the mode reads 0 (read prefetch), the fill level is 0 and the current address is 0.
- R2: A configuration write sets the requested mode (1 = page program, 0 = read prefetch). The readback mode takes the requested value within a few cycles when no command is pending. While a command is pending, the readback mode does not change.
- R3: Each accepted data-port write stores one 32-bit word at the word pointer and advances the pointer. The fill level reports the pointer. Once 32 words are stored, further writes are dropped and the fill level stays 32.
- R4: Data-port writes have no effect on the fill level while the mode reads 0 or while a command is pending.
- R5: Command code 0x10, accepted only when the mode reads 1, produces one chip-select-low frame of 132 bytes. The frame holds opcode 0x02, then address bits 23:16, 15:8 and 7:0, then stored bytes 0 to 127. Stored byte 4k+j is bits 8j+7:8j of word k.
- R6: From the edge that accepts a command until its frame ends, the pending-command output equals the low five bits of the command code (0x10). It returns to 0 on the same edge that chip select returns high.
- R7: Accepting command 0x10 returns the word pointer, and so the fill level, to 0.
- R8: Command code 0x90 produces a 5-byte frame: opcode 0x02, the three address bytes, then the byte register. The current address increases by 1, carrying across byte boundaries, when the frame ends.
- R9: The following are ignored and produce no frame: command 0x10 while the mode reads 0, any code other than 0x10 and 0x90, and any command while one is pending.
- R10: The serial line runs in mode 0. The clock is low whenever chip select is high, and the data bit is only updated while the clock is low. Each bit is sent most significant first and sampled by the device on the rising clock edge.
- R11: An address write while no command is pending loads the 24-bit current address, which reads back on the address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the mode request |
| cfg_mode | input | 1 | Requested mode: 1 page program, 0 read prefetch |
| mode_rd | output | 1 | Mode currently in force |
| word_we | input | 1 | Data-port write strobe |
| word_data | input | 32 | Four packed bytes, byte 0 in bits 7:0 |
| addr_we | input | 1 | Address write strobe |
| addr_data | input | 24 | Flash byte address |
| wbyte_we | input | 1 | Byte-register write strobe |
| wbyte_data | input | 8 | Byte for the single-byte command |
| cmd_we | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x10 page, 0x90 single byte) |
| cmd_pending | output | 5 | Low command bits while busy, 0 when done |
| cur_addr | output | 24 | Current flash address |
| fill_level | output | 6 | Words stored since the last page command |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |

## Verification
A wrong byte lane shows at the serial line in the first data byte of a page frame, about 8 serial clocks after the address. A word pointer that is not cleared shows on the fill level one cycle after the command edge. A wrong data-port gate shows on the fill level one cycle after the write. A busy flag that is out of step with the shifter shows the same cycle as a pending output that disagrees with chip select. A skipped or extra address increment shows in the address bytes of the next single-byte frame and on the address output at frame end. The mode hold shows as a readback change while the pending bits are nonzero.

// File: rtl/nor_pp_pkg.sv
package nor_pp_pkg;
    localparam logic [7:0] CMD_PAGE_BURST  = 8'h10;
    localparam logic [7:0] CMD_SINGLE_BYTE = 8'h90;
    localparam logic [7:0] FLASH_OP_PROGRAM = 8'h02;

    typedef enum logic {
        SRC_BUFFER = 1'b0,
        SRC_SINGLE = 1'b1
    } data_src_e;
endpackage

// File: rtl/nor_pp_stage.sv
// Page staging store: word-wide fill port, byte-wide read port.
module nor_pp_stage #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          wr_en,
    input  logic [DATA_W-1:0]                             wr_word,
    input  logic                                          clr,
    input  logic [$clog2(WORDS*(DATA_W/8))-1:0]           rd_idx,
    output logic [7:0]                                    rd_byte,
    output logic [$clog2(WORDS+1)-1:0]                    fill
);
    localparam int LANES = DATA_W / 8;
    localparam int LW    = $clog2(LANES);
    localparam int BIW   = $clog2(WORDS * LANES);
    localparam int WIW   = $clog2(WORDS);
    localparam int PW    = $clog2(WORDS + 1);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                ptr;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (wr_en && (st_q.ptr < PW'(WORDS))) begin
            st_d.mem[st_q.ptr[WIW-1:0]] = wr_word;
            st_d.ptr = st_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lane select: byte j of a word sits in bits 8j+7:8j.
    logic [WIW-1:0]   word_sel;
    logic [LW-1:0]    lane_sel;
    logic [DATA_W-1:0] word_out;
    logic [7:0]       lane_byte [LANES];

    assign word_sel = rd_idx[BIW-1:LW];
    assign lane_sel = rd_idx[LW-1:0];
    assign word_out = st_q.mem[word_sel];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = word_out[g*8 +: 8];
    end

    assign rd_byte = lane_byte[lane_sel];
    assign fill    = st_q.ptr;
endmodule

// File: rtl/nor_pp_serial.sv
// Mode-0 byte serializer: one chip-select frame of bytes 0..last_idx.
module nor_pp_serial #(
    parameter int HALF = 2,
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IDXW-1:0] last_idx,
    output logic [IDXW-1:0] fetch_idx,
    input  logic [7:0]      fetch_byte,
    output logic            sck,
    output logic            cs_n,
    output logic            mosi,
    output logic            done
);
    localparam int DVW = $clog2(HALF + 1);

    typedef struct packed {
        logic            active;
        logic            sck;
        logic [7:0]      sr;
        logic [2:0]      bitn;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] last;
        logic [DVW-1:0]  div;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        done      = 1'b0;
        fetch_idx = st_q.active ? (st_q.idx + IDXW'(1)) : '0;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.sck    = 1'b0;
                st_d.sr     = fetch_byte;
                st_d.bitn   = '0;
                st_d.idx    = '0;
                st_d.last   = last_idx;
                st_d.div    = '0;
            end
        end else if (st_q.div == DVW'(HALF - 1)) begin
            st_d.div = '0;
            if (!st_q.sck) begin
                st_d.sck = 1'b1;
            end else begin
                st_d.sck = 1'b0;
                if (st_q.bitn == 3'd7) begin
                    if (st_q.idx == st_q.last) begin
                        st_d.active = 1'b0;
                        done        = 1'b1;
                    end else begin
                        st_d.idx  = st_q.idx + IDXW'(1);
                        st_d.sr   = fetch_byte;
                        st_d.bitn = '0;
                    end
                end else begin
                    st_d.sr   = {st_q.sr[6:0], 1'b0};
                    st_d.bitn = st_q.bitn + 3'd1;
                end
            end
        end else begin
            st_d.div = st_q.div + DVW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck  = st_q.sck;
    assign cs_n = !st_q.active;
    assign mosi = st_q.active & st_q.sr[7];
endmodule

// File: rtl/nor_pp_writer.sv
module nor_pp_writer
    import nor_pp_pkg::*;
#(
    parameter int WORDS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int HALF   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic                          cfg_mode,
    output logic                          mode_rd,
    input  logic                          word_we,
    input  logic [DATA_W-1:0]             word_data,
    input  logic                          addr_we,
    input  logic [ADDR_W-1:0]             addr_data,
    input  logic                          wbyte_we,
    input  logic [7:0]                    wbyte_data,
    input  logic                          cmd_we,
    input  logic [7:0]                    cmd_code,
    output logic [4:0]                    cmd_pending,
    output logic [ADDR_W-1:0]             cur_addr,
    output logic [$clog2(WORDS+1)-1:0]    fill_level,
    output logic                          spi_sck,
    output logic                          spi_cs_n,
    output logic                          spi_mosi
);
    localparam int BYTES = WORDS * (DATA_W / 8);
    localparam int HDR   = ADDR_W / 8 + 1;
    localparam int IDXW  = $clog2(HDR + BYTES);
    localparam int BIW   = $clog2(BYTES);
    localparam int HIW   = $clog2(HDR);

    typedef struct packed {
        logic              mode_req;
        logic              mode;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wbyte;
        logic [4:0]        pend;
        data_src_e         src;
    } ctl_t;

    ctl_t st_d, st_q;

    logic            idle;
    logic            accept_page;
    logic            accept_one;
    logic            ser_start;
    logic            ser_done;
    logic [IDXW-1:0] ser_last;
    logic [IDXW-1:0] fetch_idx;
    logic [7:0]      fetch_byte;
    logic [BIW-1:0]  buf_idx;
    logic [7:0]      buf_byte;
    logic            buf_we;
    logic [7:0]      hdr_byte [HDR];

    // Header bytes: opcode, then the address most significant byte first.
    assign hdr_byte[0] = FLASH_OP_PROGRAM;
    for (genvar g = 1; g < HDR; g++) begin : g_hdr
        assign hdr_byte[g] = st_q.addr[(HDR-1-g)*8 +: 8];
    end

    always_comb begin
        idle        = (st_q.pend == 5'd0);
        accept_page = cmd_we && idle && (cmd_code == CMD_PAGE_BURST) && st_q.mode;
        accept_one  = cmd_we && idle && (cmd_code == CMD_SINGLE_BYTE);
        ser_start   = accept_page || accept_one;
        ser_last    = accept_page ? IDXW'(HDR + BYTES - 1) : IDXW'(HDR);
        buf_we      = word_we && idle && st_q.mode;
        buf_idx     = BIW'(fetch_idx - IDXW'(HDR));

        if (fetch_idx < IDXW'(HDR))        fetch_byte = hdr_byte[fetch_idx[HIW-1:0]];
        else if (st_q.src == SRC_SINGLE)   fetch_byte = st_q.wbyte;
        else                               fetch_byte = buf_byte;

        st_d = st_q;
        if (cfg_we) st_d.mode_req = cfg_mode;
        if (idle)   st_d.mode     = st_q.mode_req;
        if (addr_we && idle)  st_d.addr  = addr_data;
        if (wbyte_we && idle) st_d.wbyte = wbyte_data;
        if (ser_start) begin
            st_d.pend = cmd_code[4:0];
            st_d.src  = accept_page ? SRC_BUFFER : SRC_SINGLE;
        end else if (ser_done) begin
            st_d.pend = 5'd0;
            if (st_q.src == SRC_SINGLE) st_d.addr = st_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nor_pp_stage #(
        .WORDS (WORDS),
        .DATA_W(DATA_W)
    ) i_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_we),
        .wr_word(word_data),
        .clr    (accept_page),
        .rd_idx (buf_idx),
        .rd_byte(buf_byte),
        .fill   (fill_level)
    );

    nor_pp_serial #(
        .HALF(HALF),
        .IDXW(IDXW)
    ) i_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ser_start),
        .last_idx  (ser_last),
        .fetch_idx (fetch_idx),
        .fetch_byte(fetch_byte),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .done      (ser_done)
    );

    assign mode_rd     = st_q.mode;
    assign cmd_pending = st_q.pend;
    assign cur_addr    = st_q.addr;
endmodule

// File: rtl/nor_pp_writer_chk.sv
module nor_pp_writer_chk #(
    parameter int WORDS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mode_rd,
    input logic                       word_we,
    input logic [4:0]                 cmd_pending,
    input logic [$clog2(WORDS+1)-1:0] fill_level,
    input logic                       spi_sck,
    input logic                       spi_cs_n,
    input logic                       spi_mosi
);
    assert_sck_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_steady_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_pending_tracks_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending != 5'd0) == !spi_cs_n);

    assert_fill_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= ($clog2(WORDS+1))'(WORDS));

    assert_readmode_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_rd && word_we) |=> $stable(fill_level));

    assert_mode_held_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending != 5'd0) |=> $stable(mode_rd));
endmodule

bind nor_pp_writer nor_pp_writer_chk #(.WORDS(WORDS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_rd    (mode_rd),
    .word_we    (word_we),
    .cmd_pending(cmd_pending),
    .fill_level (fill_level),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi)
);

// File: tb/test_nor_pp_writer.sv
module test_nor_pp_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_mode = 1'b0;
    logic        word_we = 1'b0;
    logic [31:0] word_data = '0;
    logic        addr_we = 1'b0;
    logic [23:0] addr_data = '0;
    logic        wbyte_we = 1'b0;
    logic [7:0]  wbyte_data = '0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        mode_rd;
    logic [4:0]  cmd_pending;
    logic [23:0] cur_addr;
    logic [5:0]  fill_level;
    logic        spi_sck, spi_cs_n, spi_mosi;

    always #4 clk = ~clk;

    nor_pp_writer i_nor_pp_writer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode_rd(mode_rd),
        .word_we(word_we), .word_data(word_data), .addr_we(addr_we), .addr_data(addr_data),
        .wbyte_we(wbyte_we), .wbyte_data(wbyte_data), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .cmd_pending(cmd_pending), .cur_addr(cur_addr), .fill_level(fill_level),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard queues filled by the driver, drained by the monitor.
    logic [7:0] exp_q[$];
    int         len_q[$];
    string      tag_q[$];
    int         frames_seen = 0;
    int         frame_bytes = 0;
    int         nbits = 0;
    logic [7:0] shreg = '0;
    logic       sck_prev = 1'b0;
    logic       cs_prev = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && spi_sck && !sck_prev) begin
                shreg = {shreg[6:0], spi_mosi};
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    frame_bytes++;
                    if (exp_q.size() == 0) begin
                        check("R9 unexpected frame byte", {24'd0, shreg}, 32'hFFFF_FFFF);
                    end else begin
                        check(tag_q.size() > 0 ? tag_q[0] : "R9 stray", {24'd0, shreg},
                              {24'd0, exp_q.pop_front()});
                    end
                end
            end
            if (spi_cs_n && !cs_prev) begin
                frames_seen++;
                if (len_q.size() == 0) begin
                    check("R9 unexpected frame", frame_bytes, 0);
                end else begin
                    check({tag_q[0], " frame length"}, frame_bytes, len_q.pop_front());
                    check({tag_q.pop_front(), " whole bytes"}, nbits, 0);
                end
                frame_bytes = 0;
                nbits = 0;
            end
            sck_prev = spi_sck;
            cs_prev  = spi_cs_n;
        end
    end

    function automatic logic [7:0] pat(input int page, input int i);
        return 8'((i * 37) + (page * 91) + 5);
    endfunction

    task automatic strobe_cfg(input logic m);
        @(posedge clk); #1; cfg_we = 1'b1; cfg_mode = m;
        @(posedge clk); #1; cfg_we = 1'b0;
    endtask
    task automatic strobe_word(input logic [31:0] w);
        @(posedge clk); #1; word_we = 1'b1; word_data = w;
        @(posedge clk); #1; word_we = 1'b0;
    endtask
    task automatic strobe_addr(input logic [23:0] a);
        @(posedge clk); #1; addr_we = 1'b1; addr_data = a;
        @(posedge clk); #1; addr_we = 1'b0;
    endtask
    task automatic strobe_byte(input logic [7:0] b);
        @(posedge clk); #1; wbyte_we = 1'b1; wbyte_data = b;
        @(posedge clk); #1; wbyte_we = 1'b0;
    endtask
    task automatic strobe_cmd(input logic [7:0] c);
        @(posedge clk); #1; cmd_we = 1'b1; cmd_code = c;
        @(posedge clk); #1; cmd_we = 1'b0;
    endtask

    task automatic poll_mode(input logic m, input string req);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (mode_rd == m) break;
        end
        check(req, {31'd0, mode_rd}, {31'd0, m});
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (cmd_pending == 5'd0 && spi_cs_n) break;
        end
        @(negedge clk);
    endtask

    task automatic load_page(input int page);
        for (int w = 0; w < 32; w++) begin
            strobe_word({pat(page, 4*w+3), pat(page, 4*w+2), pat(page, 4*w+1), pat(page, 4*w)});
        end
    endtask

    task automatic expect_page(input int page, input logic [23:0] a);
        exp_q.push_back(8'h02);
        exp_q.push_back(a[23:16]);
        exp_q.push_back(a[15:8]);
        exp_q.push_back(a[7:0]);
        for (int i = 0; i < 128; i++) exp_q.push_back(pat(page, i));
        len_q.push_back(132);
        tag_q.push_back("R5");
    endtask

    task automatic expect_single(input logic [23:0] a, input logic [7:0] b);
        exp_q.push_back(8'h02);
        exp_q.push_back(a[23:16]);
        exp_q.push_back(a[15:8]);
        exp_q.push_back(a[7:0]);
        exp_q.push_back(b);
        len_q.push_back(5);
        tag_q.push_back("R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
        check("R1 sck", {31'd0, spi_sck}, 32'd0);
        check("R1 pending", {27'd0, cmd_pending}, 32'd0);
        check("R1 mode", {31'd0, mode_rd}, 32'd0);
        check("R1 fill", {26'd0, fill_level}, 32'd0);
        check("R1 addr", {8'd0, cur_addr}, 32'd0);

        // R4: data port ignored in read mode.
        strobe_word(32'hDEAD_BEEF);
        strobe_word(32'h0123_4567);
        @(negedge clk);
        check("R4 fill in read mode", {26'd0, fill_level}, 32'd0);

        strobe_cfg(1'b1);
        poll_mode(1'b1, "R2 mode to page");

        // R3: fill and overflow drop.
        load_page(1);
        @(negedge clk);
        check("R3 fill full", {26'd0, fill_level}, 32'd32);
        strobe_word(32'hFFFF_FFFF);
        @(negedge clk);
        check("R3 fill after overflow", {26'd0, fill_level}, 32'd32);

        strobe_addr(24'h12_3456);
        @(negedge clk);
        check("R11 address load", {8'd0, cur_addr}, 32'h0012_3456);

        expect_page(1, 24'h12_3456);
        strobe_cmd(8'h10);
        @(negedge clk);
        check("R6 pending while busy", {27'd0, cmd_pending}, 32'h10);
        check("R7 pointer cleared", {26'd0, fill_level}, 32'd0);
        strobe_word(32'hAAAA_5555);
        @(negedge clk);
        check("R4 fill while busy", {26'd0, fill_level}, 32'd0);
        strobe_cmd(8'h90);
        @(negedge clk);
        check("R9 command while busy", {27'd0, cmd_pending}, 32'h10);
        strobe_addr(24'h00_0001);
        @(negedge clk);
        check("R11 address held while busy", {8'd0, cur_addr}, 32'h0012_3456);
        strobe_cfg(1'b0);
        repeat (4) @(negedge clk);
        check("R2 mode held while busy", {31'd0, mode_rd}, 32'd1);
        wait_idle();
        check("R6 pending cleared", {27'd0, cmd_pending}, 32'd0);
        check("R6 cs released", {31'd0, spi_cs_n}, 32'd1);
        poll_mode(1'b0, "R2 mode back to read");

        // R9: page command in read mode and an unknown code.
        strobe_cmd(8'h10);
        @(negedge clk);
        check("R9 page in read mode", {27'd0, cmd_pending}, 32'd0);
        strobe_cmd(8'h04);
        @(negedge clk);
        check("R9 unknown code", {27'd0, cmd_pending}, 32'd0);
        repeat (20) @(negedge clk);
        check("R9 no frame", {31'd0, spi_cs_n}, 32'd1);

        // Second page reuses the store after the pointer reset.
        strobe_cfg(1'b1);
        poll_mode(1'b1, "R2 mode to page again");
        load_page(2);
        @(negedge clk);
        check("R3 refill", {26'd0, fill_level}, 32'd32);
        strobe_addr(24'h00_0080);
        expect_page(2, 24'h00_0080);
        strobe_cmd(8'h10);
        wait_idle();
        strobe_cfg(1'b0);
        poll_mode(1'b0, "R2 read before tail");

        // R8: tail bytes with carry across a byte boundary.
        strobe_addr(24'h00_FFFE);
        strobe_byte(8'h5A);
        expect_single(24'h00_FFFE, 8'h5A);
        strobe_cmd(8'h90);
        @(negedge clk);
        check("R6 pending single", {27'd0, cmd_pending}, 32'h10);
        wait_idle();
        check("R8 address step", {8'd0, cur_addr}, 32'h0000_FFFF);
        strobe_byte(8'hC3);
        expect_single(24'h00_FFFF, 8'hC3);
        strobe_cmd(8'h90);
        wait_idle();
        check("R8 address carry", {8'd0, cur_addr}, 32'h0001_0000);

        repeat (10) @(negedge clk);
        check("R5 frames seen", frames_seen, 32'd4);
        check("R5 scoreboard drained", exp_q.size(), 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule